// File: doc/BRIEF.md
# SPI Slave Serial Engine with Run/Stop Control

This block receives serial frames from an external SPI master and returns a frame of its own on every transfer. Serial clock, chip select and data-in are asynchronous to the system clock. A two-flop synchroniser brings them into the system domain, and edge detection on the synchronised serial clock drives all shifting. Clock polarity, clock phase and frame length (4 to 16 bits) are set locally and must match the master.

A run/stop controller sits in front of the serial engine. It holds one of two states, STOPPED or RUNNING, and reports the state on a status pin. Four things can stop the engine: software start and halt pulses, a low-power stop request with a request/acknowledge handshake, a debug input gated by a freeze-enable bit, and a module-disable level that freezes the serial logic where it stands. Every stop waits for a frame boundary, so a frame is never cut in half by the controller.

The transmit side is a one-word valid/ready slot. The receive side has no back-pressure: the master owns the serial clock, so a finished frame is presented as a single-cycle valid pulse and must be taken in that cycle.

Top module: `spi_slave_runstop`

## Requirements
- R1: After reset the block is STOPPED. `running` is 0, `lp_stop_ack` is 0, `rx_valid` is 0 and `tx_ready` is 1. The defaults are CPOL 0, CPHA 0, slave role and 8-bit frames.
- R2: A `sw_start` pulse sets a run-enable flag in the next cycle, and `running` rises one cycle after that. A `sw_halt` pulse clears the flag. If both pulses arrive in the same cycle, halt wins. A halt during a frame leaves `running` at 1 until that frame has ended.
- R3: Frames are received only while the block is RUNNING, the master-select bit is 0 and `spi_cs_n` is low. Otherwise serial clock edges are ignored and `spi_miso` is 0.
- R4: The leading edge is the serial clock edge that moves away from the CPOL idle level. With CPHA 0 the data-in bit is sampled on the leading edge. With CPHA 1 it is sampled on the trailing edge. Bits go most significant first in both directions.
- R5: The frame length is the written value clamped to the range 4 to 16. When the last bit of a frame is sampled, `rx_valid` pulses for exactly one cycle and `rx_data` holds the frame right-justified, with unused upper bits at 0.
- R6: `tx_ready` is 1 while the transmit slot is empty and no low-power stop is held. A word accepted through `tx_valid`/`tx_ready` is claimed by the first sample of the next frame and shifted out from bit length-1 down to bit 0. A frame that starts with an empty slot sends zeros.
- R7: Raising chip select in the middle of a frame drops the partial frame. The next frame starts again from its first bit.
- R8: While `lp_stop_req` is high, `lp_stop_ack` stays 0 until no frame is in progress. At that point `running` goes to 0 and `lp_stop_ack` goes to 1. Dropping the request clears the acknowledge on the next cycle, and the block runs again if run-enable is still set.
- R9: While the low-power stop is acknowledged, the following are ignored: start and halt pulses, configuration writes, transmit pushes (`tx_ready` is 0) and serial traffic.
- R10: When `dbg_req` and `frz_en` are both 1, the block stops at the next frame boundary and resumes once the condition goes away. With `frz_en` at 0, `dbg_req` has no effect.
- R11: While `mdis` is 1, the serial logic holds its bit count and produces no `rx_valid`.
- R12: A `cfg_wr` pulse changes CPOL, CPHA, master-select and frame length only while the block is STOPPED. A write while RUNNING has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_start | input | 1 | Pulse: set run-enable |
| sw_halt | input | 1 | Pulse: clear run-enable (wins over start) |
| cfg_wr | input | 1 | Pulse: load the configuration fields below |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_master | input | 1 | Master-select; the block acts as slave only when 0 |
| cfg_len | input | 5 | Bits per frame, clamped to 4..16 |
| lp_stop_req | input | 1 | Low-power stop request |
| lp_stop_ack | output | 1 | Stopped at a frame boundary; clocks may be shut off |
| dbg_req | input | 1 | Debug halt request |
| frz_en | input | 1 | Lets `dbg_req` freeze the block |
| mdis | input | 1 | Module disable: freezes the serial logic |
| running | output | 1 | Status: 1 in RUNNING, 0 in STOPPED |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit slot free |
| rx_data | output | 16 | Last received frame, right-justified |
| rx_valid | output | 1 | Single-cycle pulse: frame received |

## Verification
A corrupted bit counter shows up within one frame. It causes `rx_valid` to fire at the wrong edge or not at all, and it causes a word shifted out to the master to appear rotated. The same fault can also hold the boundary signal low, so a halt, freeze or low-power request never completes and `running` or `lp_stop_ack` stays stale. A wrong run-state or handshake flag is visible at once on `running`, `lp_stop_ack` or `tx_ready`. A reference model tracks all three in every clock cycle, so such a fault is caught in the cycle where it first differs.

// File: rtl/spis_pkg.sv
package spis_pkg;

  typedef enum logic {
    ST_STOPPED = 1'b0,
    ST_RUNNING = 1'b1
  } run_st_t;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic mstr;
  } spis_mode_t;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spis_runctl.sv
module spis_runctl
  import spis_pkg::*;
#(
  parameter int MIN_BITS = 4,
  parameter int MAX_BITS = 16,
  parameter int RST_BITS = 8,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start,
  input  logic             sw_halt,
  input  logic             cfg_wr,
  input  spis_mode_t       cfg_mode_in,
  input  logic [LEN_W-1:0] cfg_len_in,
  input  logic             lp_req,
  input  logic             dbg_req,
  input  logic             frz_en,
  input  logic             idle,
  output logic             running,
  output logic             run_go,
  output logic             lp_hold,
  output spis_mode_t       mode,
  output logic [LEN_W-1:0] frame_len
);

  localparam logic [LEN_W-1:0] LEN_LO  = LEN_W'(MIN_BITS);
  localparam logic [LEN_W-1:0] LEN_HI  = LEN_W'(MAX_BITS);
  localparam logic [LEN_W-1:0] LEN_RST = LEN_W'(RST_BITS);

  run_st_t          st;
  logic             run_en;
  logic             frz;
  logic             stop_cause;
  logic             stop_now;
  logic             wr_ok;
  logic [LEN_W-1:0] len_clamped;

  assign frz        = dbg_req & frz_en;
  assign stop_cause = ~run_en | lp_req | frz;
  assign stop_now   = (st == ST_RUNNING) & stop_cause & idle;
  assign run_go     = (st == ST_RUNNING) & ~stop_now;
  assign running    = (st == ST_RUNNING);
  assign wr_ok      = ~lp_hold;

  always_comb begin
    if (cfg_len_in < LEN_LO)      len_clamped = LEN_LO;
    else if (cfg_len_in > LEN_HI) len_clamped = LEN_HI;
    else                          len_clamped = cfg_len_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_STOPPED;
      run_en    <= 1'b0;
      lp_hold   <= 1'b0;
      mode      <= '0;
      frame_len <= LEN_RST;
    end else begin
      if (wr_ok) begin
        if (sw_halt)       run_en <= 1'b0;
        else if (sw_start) run_en <= 1'b1;
      end

      if (stop_now)
        st <= ST_STOPPED;
      else if (st == ST_STOPPED && run_en && !lp_req && !frz)
        st <= ST_RUNNING;

      if (!lp_req)
        lp_hold <= 1'b0;
      else if (st == ST_STOPPED || stop_now)
        lp_hold <= 1'b1;

      if (cfg_wr && wr_ok && st == ST_STOPPED) begin
        mode      <= cfg_mode_in;
        frame_len <= len_clamped;
      end
    end
  end

  // R2
  mid_frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUNNING && !idle) |=> st == ST_RUNNING);

  // R8
  ack_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_hold |-> st == ST_STOPPED);

  // R9
  lp_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_hold && lp_req) |=> st == ST_STOPPED);

  // R10
  no_freeze_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUNNING && run_en && !lp_req && !(dbg_req && frz_en)) |=> st == ST_RUNNING);

  // R12
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUNNING) |=> $stable(frame_len));

endmodule

// File: rtl/spis_shift.sv
module spis_shift
  import spis_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_s,
  input  logic                cs_n_s,
  input  logic                mosi_s,
  input  spis_mode_t          mode,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic                run_go,
  input  logic                mdis,
  input  logic                push_block,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid,
  output logic                miso,
  output logic                idle
);

  logic                sck_d;
  logic                lvl_now, lvl_old;
  logic                lead_ev, trail_ev;
  logic                sel, sample_ev, last_bit;
  logic [LEN_W-1:0]    bit_cnt;
  logic [MAX_BITS-2:0] rx_sr;
  logic [MAX_BITS-1:0] tx_word, hold_q, cur_word, len_mask, rx_word;
  logic                hold_v;
  logic [LEN_W-1:0]    idx;
  logic                miso_bit;
  logic                tx_push;

  assign lvl_now   = sck_s ^ mode.cpol;
  assign lvl_old   = sck_d ^ mode.cpol;
  assign lead_ev   = lvl_now & ~lvl_old;
  assign trail_ev  = ~lvl_now & lvl_old;
  assign sel       = run_go & ~mode.mstr & ~cs_n_s;
  assign sample_ev = sel & (mode.cpha ? trail_ev : lead_ev);
  assign last_bit  = (bit_cnt == frame_len - LEN_W'(1));
  assign idle      = (bit_cnt == '0);
  assign tx_ready  = ~hold_v & ~push_block;
  assign tx_push   = tx_valid & tx_ready;
  assign cur_word  = idle ? (hold_v ? hold_q : '0) : tx_word;
  assign idx       = frame_len - LEN_W'(1) - bit_cnt;

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++) len_mask[i] = (LEN_W'(i) < frame_len);
  end

  assign rx_word = {rx_sr, mosi_s} & len_mask;

  always_comb begin
    miso_bit = 1'b0;
    for (int i = 0; i < MAX_BITS; i++)
      if (LEN_W'(i) == idx) miso_bit = cur_word[i];
  end

  assign miso = sel & ~mdis & miso_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d    <= 1'b0;
      bit_cnt  <= '0;
      rx_sr    <= '0;
      tx_word  <= '0;
      hold_q   <= '0;
      hold_v   <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      rx_valid <= 1'b0;
      if (!mdis) begin
        if (!sel) begin
          bit_cnt <= '0;
        end else if (sample_ev) begin
          rx_sr <= rx_word[MAX_BITS-2:0];
          if (idle) begin
            tx_word <= cur_word;
            if (hold_v) hold_v <= 1'b0;
          end
          if (last_bit) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_word;
            bit_cnt  <= '0;
          end else begin
            bit_cnt <= bit_cnt + LEN_W'(1);
          end
        end
      end
      if (tx_push) begin
        hold_q <= tx_data;
        hold_v <= 1'b1;
      end
    end
  end

  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < frame_len);

  // R11
  mdis_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdis |=> ($stable(bit_cnt) && !rx_valid));

  // R3
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !miso);

endmodule

// File: rtl/spi_slave_runstop.sv
module spi_slave_runstop
  import spis_pkg::*;
#(
  parameter int MIN_BITS = 4,
  parameter int MAX_BITS = 16,
  parameter int RST_BITS = 8,
  parameter int SYNC_STAGES = 2,
  localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sw_start,
  input  logic                sw_halt,
  input  logic                cfg_wr,
  input  logic                cfg_cpol,
  input  logic                cfg_cpha,
  input  logic                cfg_master,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                lp_stop_req,
  output logic                lp_stop_ack,
  input  logic                dbg_req,
  input  logic                frz_en,
  input  logic                mdis,
  output logic                running,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  input  logic                spi_mosi,
  output logic                spi_miso,
  input  logic [MAX_BITS-1:0] tx_data,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                rx_valid
);

  logic [2:0]       pins_s;
  spis_mode_t       mode, mode_in;
  logic [LEN_W-1:0] frame_len;
  logic             run_go, idle, lp_hold;

  assign mode_in = '{cpol: cfg_cpol, cpha: cfg_cpha, mstr: cfg_master};

  spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({spi_sck, spi_cs_n, spi_mosi}),
    .q (pins_s)
  );

  spis_runctl #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS), .RST_BITS(RST_BITS), .LEN_W(LEN_W)) u_ctl (
    .clk (clk),
    .rst_n (rst_n),
    .sw_start (sw_start),
    .sw_halt (sw_halt),
    .cfg_wr (cfg_wr),
    .cfg_mode_in (mode_in),
    .cfg_len_in (cfg_len),
    .lp_req (lp_stop_req),
    .dbg_req (dbg_req),
    .frz_en (frz_en),
    .idle (idle),
    .running (running),
    .run_go (run_go),
    .lp_hold (lp_hold),
    .mode (mode),
    .frame_len (frame_len)
  );

  spis_shift #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
    .clk (clk),
    .rst_n (rst_n),
    .sck_s (pins_s[2]),
    .cs_n_s (pins_s[1]),
    .mosi_s (pins_s[0]),
    .mode (mode),
    .frame_len (frame_len),
    .run_go (run_go),
    .mdis (mdis),
    .push_block (lp_hold),
    .tx_data (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_data (rx_data),
    .rx_valid (rx_valid),
    .miso (spi_miso),
    .idle (idle)
  );

  assign lp_stop_ack = lp_hold;

endmodule

// File: tb/spi_slave_runstop_test.sv
`timescale 1ns/1ps
module spi_slave_runstop_test;

  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_start = 0, sw_halt = 0, cfg_wr = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_master = 0;
  logic [4:0] cfg_len = 5'd8;
  logic lp_stop_req = 0, dbg_req = 0, frz_en = 0, mdis = 0;
  logic spi_sck = 0, spi_cs_n = 1, spi_mosi = 0;
  logic [15:0] tx_data = 0;
  logic tx_valid = 0;
  logic lp_stop_ack, running, spi_miso, tx_ready, rx_valid;
  logic [15:0] rx_data;

  always #4 clk = ~clk;

  spi_slave_runstop uut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int ms_sck[3], ms_cs[2], ms_mo[2];
  int m_cpol, m_cpha, m_mstr, m_len, m_run_en, m_running, m_lp;
  int m_cnt, m_acc, m_hold_v, m_rxv, m_rxd;
  int le, te, frz_a, cause, stopnow, go, en_m, smp, push, consume, nrun, nlp, cl;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms_sck = '{0, 0, 0}; ms_cs = '{1, 1}; ms_mo = '{0, 0};
      m_cpol = 0; m_cpha = 0; m_mstr = 0; m_len = 8;
      m_run_en = 0; m_running = 0; m_lp = 0;
      m_cnt = 0; m_acc = 0; m_hold_v = 0; m_rxv = 0; m_rxd = 0;
    end else begin
      le = ((ms_sck[1] ^ m_cpol) == 1) && ((ms_sck[2] ^ m_cpol) == 0);
      te = ((ms_sck[1] ^ m_cpol) == 0) && ((ms_sck[2] ^ m_cpol) == 1);
      frz_a = dbg_req && frz_en;
      cause = !m_run_en || lp_stop_req || frz_a;
      stopnow = m_running && cause && (m_cnt == 0);
      go = m_running && !stopnow;
      en_m = go && !m_mstr && !ms_cs[1];
      smp = en_m && (m_cpha ? te : le);
      push = tx_valid && !m_hold_v && !m_lp;
      consume = 0;
      m_rxv = 0;
      if (!mdis) begin
        if (!en_m) m_cnt = 0;
        else if (smp) begin
          if (m_cnt == 0) begin m_acc = ms_mo[1]; consume = m_hold_v; end
          else m_acc = (m_acc << 1) | ms_mo[1];
          if (m_cnt == m_len - 1) begin m_rxv = 1; m_rxd = m_acc; m_cnt = 0; end
          else m_cnt++;
        end
      end
      if (push) m_hold_v = 1; else if (consume) m_hold_v = 0;
      if (!lp_stop_req) nlp = 0; else if (!m_running || stopnow) nlp = 1; else nlp = m_lp;
      if (stopnow) nrun = 0;
      else if (!m_running && m_run_en && !lp_stop_req && !frz_a) nrun = 1;
      else nrun = m_running;
      if (!m_lp) begin
        if (sw_halt) m_run_en = 0; else if (sw_start) m_run_en = 1;
      end
      if (cfg_wr && !m_running && !m_lp) begin
        cl = cfg_len; if (cl < 4) cl = 4; if (cl > 16) cl = 16;
        m_cpol = cfg_cpol; m_cpha = cfg_cpha; m_mstr = cfg_master; m_len = cl;
      end
      m_running = nrun; m_lp = nlp;
      ms_sck[2] = ms_sck[1]; ms_sck[1] = ms_sck[0]; ms_sck[0] = spi_sck;
      ms_cs[1] = ms_cs[0]; ms_cs[0] = spi_cs_n;
      ms_mo[1] = ms_mo[0]; ms_mo[0] = spi_mosi;
    end
  end

  int n_rx = 0;
  int last_rx = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(running == m_running[0], "R2 running", running, m_running);
      check(lp_stop_ack == m_lp[0], "R8 ack", lp_stop_ack, m_lp);
      check(tx_ready == (!m_hold_v && !m_lp), "R6 tx_ready", tx_ready, !m_hold_v && !m_lp);
      check(rx_valid == m_rxv[0], "R5 rx_valid", rx_valid, m_rxv);
      check(rx_data == m_rxd[15:0], "R5 rx_data", rx_data, m_rxd);
      if (rx_valid) begin n_rx++; last_rx = rx_data; end
    end
  end

  // ---------------- stimulus helpers ----------------
  int b_cpol = 0, b_cpha = 0;

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(); sw_start = 1; waitc(1); sw_start = 0; endtask
  task automatic pulse_halt();  sw_halt = 1;  waitc(1); sw_halt = 0;  endtask

  task automatic cfg(input int cp, input int ch, input int ms, input int ln);
    cfg_cpol = cp[0]; cfg_cpha = ch[0]; cfg_master = ms[0]; cfg_len = ln[4:0];
    cfg_wr = 1; waitc(1); cfg_wr = 0;
  endtask

  task automatic push_tx(input int w);
    tx_data = w[15:0]; tx_valid = 1; waitc(1); tx_valid = 0;
  endtask

  task automatic xfer(input int nb, input int w, input int stop_at, output int got);
    got = 0;
    spi_sck = b_cpol[0];
    spi_cs_n = 0;
    for (int i = nb - 1; i >= 0; i--) begin
      if (nb - 1 - i == stop_at) break;
      if (b_cpha == 0) begin
        spi_mosi = w[i]; waitc(HALF);
        spi_sck = ~b_cpol[0]; got = (got << 1) | spi_miso; waitc(HALF);
        spi_sck = b_cpol[0];
      end else begin
        waitc(HALF); spi_sck = ~b_cpol[0]; spi_mosi = w[i]; waitc(HALF);
        spi_sck = b_cpol[0]; got = (got << 1) | spi_miso;
      end
    end
    waitc(HALF); spi_cs_n = 1; waitc(2 * HALF);
  endtask

  task automatic restart(input int cp, input int ch, input int ms, input int ln);
    pulse_halt(); waitc(3);
    b_cpol = cp; b_cpha = ch; spi_sck = cp[0];
    cfg(cp, ch, ms, ln); waitc(4);
    pulse_start(); waitc(3);
  endtask

  int got, nr;

  initial begin
    waitc(4); rst_n = 1; waitc(1);
    // R1 reset state
    check(running == 0, "R1 running", running, 0);
    check(lp_stop_ack == 0, "R1 ack", lp_stop_ack, 0);
    check(rx_valid == 0, "R1 rx_valid", rx_valid, 0);
    check(tx_ready == 1, "R1 tx_ready", tx_ready, 1);

    // R2 start timing
    cfg(0, 0, 0, 8);
    sw_start = 1; waitc(1); sw_start = 0;
    check(running == 0, "R2 start+1", running, 0);
    waitc(1);
    check(running == 1, "R2 start+2", running, 1);

    // R4 R6 mode 0 with tx word
    push_tx(16'hA5);
    check(tx_ready == 0, "R6 slot full", tx_ready, 0);
    nr = n_rx; xfer(8, 8'h3C, -1, got);
    check(n_rx == nr + 1 && last_rx == 16'h3C, "R4 mode0 rx", last_rx, 16'h3C);
    check(got == 16'hA5, "R6 miso word", got, 16'hA5);
    check(tx_ready == 1, "R6 slot freed", tx_ready, 1);
    xfer(8, 8'hC3, -1, got);
    check(got == 0, "R6 empty slot zeros", got, 0);

    // R12 write while running ignored
    cfg(1, 1, 0, 4); waitc(2);
    nr = n_rx; xfer(8, 8'h96, -1, got);
    check(n_rx == nr + 1 && last_rx == 16'h96, "R12 cfg locked", last_rx, 16'h96);

    // R2 halt mid-frame
    fork
      xfer(8, 8'h5E, -1, got);
      begin waitc(30); pulse_halt(); waitc(5);
        check(running == 1, "R2 halt waits", running, 1); end
    join
    check(running == 0, "R2 halt done", running, 0);
    check(last_rx == 16'h5E, "R2 frame completed", last_rx, 16'h5E);

    // R4 R6 cpol1 cpha1 12-bit
    restart(1, 1, 0, 12);
    push_tx(16'hABC);
    nr = n_rx; xfer(12, 12'h5A3, -1, got);
    check(n_rx == nr + 1 && last_rx == 16'h5A3, "R4 mode3 rx", last_rx, 16'h5A3);
    check(got == 16'hABC, "R6 mode3 miso", got, 16'hABC);

    // R5 clamp high, cpol0 cpha1
    restart(0, 1, 0, 20);
    push_tx(16'h1234);
    nr = n_rx; xfer(16, 16'hBEEF, -1, got);
    check(last_rx == 16'hBEEF && n_rx == nr + 1, "R5 clamp 16", last_rx, 16'hBEEF);
    check(got == 16'h1234, "R6 16-bit miso", got, 16'h1234);

    // R5 clamp low, cpol1 cpha0
    restart(1, 0, 0, 2);
    nr = n_rx; xfer(4, 4'h9, -1, got);
    check(last_rx == 16'h9 && n_rx == nr + 1, "R5 clamp 4", last_rx, 16'h9);

    // R3 master-select set
    restart(0, 0, 1, 8);
    nr = n_rx; xfer(8, 8'h77, -1, got);
    check(n_rx == nr, "R3 master role no rx", n_rx, nr);

    // R3 clocks without chip select
    restart(0, 0, 0, 8);
    nr = n_rx;
    for (int k = 0; k < 16; k++) begin spi_sck = ~spi_sck; waitc(HALF); end
    spi_sck = 0; waitc(4);
    check(n_rx == nr, "R3 cs high no rx", n_rx, nr);

    // R7 abort then full frame
    xfer(8, 8'hFF, 3, got);
    nr = n_rx; xfer(8, 8'h71, -1, got);
    check(n_rx == nr + 1 && last_rx == 16'h71, "R7 restart after abort", last_rx, 16'h71);

    // R8 low-power stop mid-frame
    fork
      xfer(8, 8'h2D, -1, got);
      begin waitc(30); lp_stop_req = 1; waitc(3);
        check(lp_stop_ack == 0, "R8 ack withheld", lp_stop_ack, 0); end
    join
    check(lp_stop_ack == 1 && running == 0, "R8 ack at boundary", lp_stop_ack, 1);
    check(last_rx == 16'h2D, "R8 frame completed", last_rx, 16'h2D);

    // R9 ignored while stopped for low power
    check(tx_ready == 0, "R9 no push", tx_ready, 0);
    pulse_halt(); cfg(0, 0, 0, 4);
    nr = n_rx; xfer(8, 8'h44, -1, got);
    check(n_rx == nr, "R9 serial ignored", n_rx, nr);
    lp_stop_req = 0; waitc(1);
    check(lp_stop_ack == 0, "R8 ack released", lp_stop_ack, 0);
    waitc(3);
    check(running == 1, "R9 halt ignored", running, 1);
    nr = n_rx; xfer(8, 8'hE1, -1, got);
    check(n_rx == nr + 1 && last_rx == 16'hE1, "R9 cfg write ignored", last_rx, 16'hE1);

    // R10 freeze
    dbg_req = 1; waitc(10);
    check(running == 1, "R10 no freeze enable", running, 1);
    frz_en = 1; waitc(3);
    check(running == 0, "R10 frozen", running, 0);
    nr = n_rx; xfer(8, 8'h10, -1, got);
    check(n_rx == nr, "R10 no rx frozen", n_rx, nr);
    dbg_req = 0; waitc(3);
    check(running == 1, "R10 resumed", running, 1);
    frz_en = 0;

    // R11 module disable
    mdis = 1;
    nr = n_rx; xfer(8, 8'h3A, -1, got);
    check(n_rx == nr, "R11 disabled no rx", n_rx, nr);
    mdis = 0; waitc(2);
    nr = n_rx; xfer(8, 8'hA3, -1, got);
    check(n_rx == nr + 1 && last_rx == 16'hA3, "R11 resumes", last_rx, 16'hA3);

    waitc(5);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule